// File: doc/BRIEF.md
# Software-Vectored Interrupt Priority Handshake

This block decides when to interrupt the processor. It takes a set of pending interrupt sources, each with a 4-bit configured priority. It compares the best of them against a current-priority register and drives one registered request line to the processor. At the moment that line rises, the block captures the index and priority of the winning source. That captured vector then stays put until the next rising edge of the request.

Software talks to the block through a small register port with three registers.

- **Acknowledge read:** returns the captured vector. At the same time the current priority is offered to an external history stack through a push strobe, and the current priority is raised to the captured source's level.
- **End-of-interrupt write:** pulses a pop strobe and loads the value supplied by the stack back into the current priority.
- **Current-priority register:** software can also write and read the current priority directly.

The history stack itself lives outside the block.

Top module: `irq_prio_hs`

## Requirements
- R1: `irqOut` is high in a cycle exactly when, at the previous clock edge, some pending source had a priority strictly greater than the current priority and no acknowledge read was being performed.
- R2: Sources whose priority is equal to or below the current priority never raise `irqOut`. With a current priority of 15, `irqOut` stays low whatever is pending.
- R3: When several pending sources share the highest priority, the one with the lowest index is the winner.
- R4: The captured vector (index and priority) is loaded only at the edge where `irqOut` goes from 0 to 1. It holds through any later change of the pending sources until the next such edge.
- R5: An acknowledge read (`regSel` = 0, `regRd` = 1) returns the captured source index on `regRdata`, zero-extended, one clock later.
- R6: During an acknowledge read, `pushValid` is 1 and `pushData` equals the current priority in that same cycle. Otherwise `pushValid` is 0.
- R7: The acknowledge read sets the current priority to the captured source's priority and drives `irqOut` to 0, both at the same clock edge.
- R8: An end-of-interrupt write (`regSel` = 1, `regWr` = 1) drives `popReq` to 1 in that cycle and loads `popData` into the current priority at that edge. The write data has no effect.
- R9: A current-priority write (`regSel` = 2) loads `regWdata[3:0]` and ignores the upper bits. A current-priority read returns the current priority in `regRdata[3:0]` with zero upper bits, one clock later.
- R10: During and directly after reset, `irqOut`, `pushValid`, `popReq` and `regRdata` are 0, and the current priority is 0.
- R11: Once a priority has been restored by an end-of-interrupt write, a still-pending source at exactly that priority does not raise `irqOut`. Only the strict greater-than rule applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcPending | input | NUM_SRC | Pending flag per source |
| srcPrio | input | NUM_SRC*PRIO_W | Priority per source; source i occupies bits [i*PRIO_W +: PRIO_W] |
| regSel | input | 2 | Register select: 0 acknowledge, 1 end of interrupt, 2 current priority |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe (a write wins over a read in the same cycle) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Registered read data, held between reads |
| irqOut | output | 1 | Interrupt request to the processor |
| pushValid | output | 1 | Push strobe to the external history stack |
| pushData | output | PRIO_W | Priority value to push |
| popReq | output | 1 | Pop strobe to the external history stack |
| popData | input | PRIO_W | Top of the external history stack |

## Verification
The results of this block fall due at different times.

- **Same cycle:** `pushValid`, `pushData` and `popReq` are combinational. The bench checks them a short delay after driving the access, before the clock edge.
- **One edge after a stimulus:** `irqOut`, the captured vector and the current priority change at the first edge after the input change. The bench applies the change at a falling edge and samples at the next falling edge.
- **One edge after the read:** `regRdata` is registered, so the bench samples it at the falling edge after the read cycle.
- **Two edges after a priority change:** a change of current priority shows up on `irqOut` only one edge after the edge that loads it. The sweep therefore clears the pending sources before each current-priority write, so that every check sees a freshly risen request.

// File: rtl/irq_hs_pkg.sv
package irq_hs_pkg;

  typedef enum logic [1:0] {
    SEL_ACK  = 2'd0,
    SEL_EOI  = 2'd1,
    SEL_CPR  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // decoded register accesses, one-hot or zero
  typedef struct packed {
    logic ackRd;
    logic eoiWr;
    logic cprWr;
    logic cprRd;
  } hsStrobe_t;

endpackage

// File: rtl/irq_hs_arb.sv
module irq_hs_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        pending,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic                      winValid,
  output logic [IDX_W-1:0]          winIdx,
  output logic [PRIO_W-1:0]         winPrio
);

  logic [PRIO_W-1:0] prioArr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prioArr[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  // ascending scan with strict compare: lowest index wins a tie
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (!winValid || (prioArr[i] > winPrio))) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioArr[i];
      end
    end
  end

endmodule

// File: rtl/irq_hs_ctrl.sv
module irq_hs_ctrl
  import irq_hs_pkg::*;
(
  input  logic [1:0] regSel,
  input  logic       regRd,
  input  logic       regWr,
  output hsStrobe_t  strb,
  output logic       pushValid,
  output logic       popReq
);

  logic rdOnly;
  assign rdOnly = regRd && !regWr;

  always_comb begin
    strb       = '0;
    strb.ackRd = rdOnly && (regSel == SEL_ACK);
    strb.cprRd = rdOnly && (regSel == SEL_CPR);
    strb.eoiWr = regWr  && (regSel == SEL_EOI);
    strb.cprWr = regWr  && (regSel == SEL_CPR);
  end

  assign pushValid = strb.ackRd;
  assign popReq    = strb.eoiWr;

endmodule

// File: rtl/irq_hs_dp.sv
module irq_hs_dp
  import irq_hs_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsStrobe_t         strb,
  input  logic              winValid,
  input  logic [IDX_W-1:0]  winIdx,
  input  logic [PRIO_W-1:0] winPrio,
  input  logic [PRIO_W-1:0] wrPrio,
  input  logic [PRIO_W-1:0] popData,
  output logic              irqOut,
  output logic [PRIO_W-1:0] curPrio,
  output logic [IDX_W-1:0]  vecIdx,
  output logic [DATA_W-1:0] rdata
);

  logic [PRIO_W-1:0] vecPrio;
  logic              irqNext;
  logic              irqRise;

  assign irqNext = winValid && (winPrio > curPrio) && !strb.ackRd;
  assign irqRise = irqNext && !irqOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      vecIdx  <= '0;
      vecPrio <= '0;
    end else begin
      irqOut <= irqNext;
      if (irqRise) begin
        vecIdx  <= winIdx;
        vecPrio <= winPrio;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPrio <= '0;
    end else if (strb.eoiWr) begin
      curPrio <= popData;
    end else if (strb.cprWr) begin
      curPrio <= wrPrio;
    end else if (strb.ackRd) begin
      curPrio <= vecPrio;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strb.ackRd) begin
      rdata <= DATA_W'(vecIdx);
    end else if (strb.cprRd) begin
      rdata <= DATA_W'(curPrio);
    end
  end

endmodule

// File: rtl/irq_prio_hs.sv
module irq_prio_hs
  import irq_hs_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcPending,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  logic [1:0]                regSel,
  input  logic                      regRd,
  input  logic                      regWr,
  input  logic [DATA_W-1:0]         regWdata,
  output logic [DATA_W-1:0]         regRdata,
  output logic                      irqOut,
  output logic                      pushValid,
  output logic [PRIO_W-1:0]         pushData,
  output logic                      popReq,
  input  logic [PRIO_W-1:0]         popData
);

  hsStrobe_t         strb;
  logic              winValid;
  logic [IDX_W-1:0]  winIdx;
  logic [PRIO_W-1:0] winPrio;
  logic [PRIO_W-1:0] curPrio;
  logic [IDX_W-1:0]  vecIdx;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:PRIO_W];

  irq_hs_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .pending  (srcPending),
    .prioFlat (srcPrio),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winPrio  (winPrio)
  );

  irq_hs_ctrl ctrl_i (
    .regSel    (regSel),
    .regRd     (regRd),
    .regWr     (regWr),
    .strb      (strb),
    .pushValid (pushValid),
    .popReq    (popReq)
  );

  irq_hs_dp #(.PRIO_W(PRIO_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winPrio  (winPrio),
    .wrPrio   (regWdata[PRIO_W-1:0]),
    .popData  (popData),
    .irqOut   (irqOut),
    .curPrio  (curPrio),
    .vecIdx   (vecIdx),
    .rdata    (regRdata)
  );

  assign pushData = curPrio;

endmodule

// File: rtl/irq_prio_hs_chk.sv
module irq_prio_hs_chk #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_SRC-1:0]        srcPending,
  input logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input logic [1:0]                regSel,
  input logic                      regRd,
  input logic                      regWr,
  input logic [PRIO_W-1:0]         popData,
  input logic                      irqOut,
  input logic                      pushValid,
  input logic [PRIO_W-1:0]         pushData,
  input logic                      popReq,
  input logic [PRIO_W-1:0]         curPrio,
  input logic [IDX_W-1:0]          vecIdx
);

  logic aboveRef;
  logic ackRef;
  logic eoiRef;

  assign ackRef = regRd && !regWr && (regSel == 2'd0);
  assign eoiRef = regWr && (regSel == 2'd1);

  always_comb begin
    aboveRef = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcPending[i] && (srcPrio[i*PRIO_W +: PRIO_W] > curPrio)) aboveRef = 1'b1;
    end
  end

  // R1
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(aboveRef));

  // R2
  top_prio_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curPrio == {PRIO_W{1'b1}}) |=> !irqOut);

  // R4
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(irqOut) |-> $stable(vecIdx));

  // R6
  push_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackRef |-> (pushValid && (pushData == curPrio)));

  // R7
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackRef |=> !irqOut);

  // R8
  pop_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiRef |=> (curPrio == $past(popData)));

  // R8
  pop_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    popReq == eoiRef);

endmodule

bind irq_prio_hs irq_prio_hs_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .srcPending (srcPending),
  .srcPrio    (srcPrio),
  .regSel     (regSel),
  .regRd      (regRd),
  .regWr      (regWr),
  .popData    (popData),
  .irqOut     (irqOut),
  .pushValid  (pushValid),
  .pushData   (pushData),
  .popReq     (popReq),
  .curPrio    (curPrio),
  .vecIdx     (vecIdx)
);

// File: tb/irq_prio_hs_tb_top.sv
`timescale 1ns/1ps
module irq_prio_hs_tb_top;
  localparam int NS = 4;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcPending = '0;
  logic [NS*PW-1:0] srcPrio = '0;
  logic [1:0]    regSel = 2'd3;
  logic          regRd = 1'b0;
  logic          regWr = 1'b0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          irqOut, pushValid, popReq;
  logic [PW-1:0] pushData;
  logic [PW-1:0] popData = '0;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;
  int pt [3][4] = '{'{3, 7, 7, 12}, '{15, 1, 5, 5}, '{0, 9, 2, 9}};

  always #5 clk = ~clk;

  irq_prio_hs #(.NUM_SRC(NS), .PRIO_W(PW), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .srcPending(srcPending), .srcPrio(srcPrio),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .pushValid(pushValid),
    .pushData(pushData), .popReq(popReq), .popData(popData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [7:0] d);
    regSel = s; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] s, output logic [7:0] d);
    regSel = s; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic ackRead(input logic [PW-1:0] expPush, output logic [7:0] d);
    regSel = 2'd0; regRd = 1'b1;
    #1;
    chk("R6 pushValid", 32'(pushValid), 32'd1);
    chk("R6 pushData", 32'(pushData), 32'(expPush));
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
    chk("R7 irq cleared by ack", 32'(irqOut), 32'd0);
  endtask

  task automatic eoiWrite(input logic [PW-1:0] pv, input logic [7:0] wd);
    popData = pv; regSel = 2'd1; regWdata = wd; regWr = 1'b1;
    #1;
    chk("R8 popReq", 32'(popReq), 32'd1);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R10 irqOut in reset", 32'(irqOut), 32'd0);
    chk("R10 rdata in reset", 32'(regRdata), 32'd0);
    chk("R10 pushValid in reset", 32'(pushValid), 32'd0);
    chk("R10 popReq in reset", 32'(popReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 irqOut after reset", 32'(irqOut), 32'd0);
    rdReg(2'd2, d);
    chk("R10 curPrio after reset", 32'(d), 32'd0);

    // sweep: priority sets x current priority x pending pattern
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < NS; i++) srcPrio[i*PW +: PW] = PW'(pt[s][i]);
      for (int cp = 0; cp < 16; cp++) begin
        for (int p = 0; p < 16; p++) begin
          int bp;
          int bi;
          bit expIrq;
          srcPending = '0;
          wrReg(2'd2, 8'(cp));
          srcPending = NS'(p);
          @(negedge clk);
          bp = -1; bi = 0;
          for (int i = 0; i < NS; i++)
            if (p[i] && (pt[s][i] > bp)) begin bp = pt[s][i]; bi = i; end
          expIrq = (bp > cp);
          if (expIrq) chk("R1 irq raised", 32'(irqOut), 32'd1);
          else        chk("R2 irq held low", 32'(irqOut), 32'd0);
          if (expIrq) begin
            ackRead(PW'(cp), d);
            chk("R3/R5 vector", 32'(d), 32'(bi));
            rdReg(2'd2, d);
            chk("R7 prio raised", 32'(d), 32'(bp));
            eoiWrite(PW'(cp), 8'hA5);
            rdReg(2'd2, d);
            chk("R8 prio restored", 32'(d), 32'(cp));
          end
        end
      end
    end

    // vector hold and relatch, set A
    for (int i = 0; i < NS; i++) srcPrio[i*PW +: PW] = PW'(pt[0][i]);
    srcPending = '0;
    wrReg(2'd2, 8'd0);
    srcPending = 4'b0001;
    @(negedge clk);
    chk("R4 first rise", 32'(irqOut), 32'd1);
    srcPending = 4'b1001;
    @(negedge clk);
    chk("R4 irq stays high", 32'(irqOut), 32'd1);
    @(negedge clk);
    ackRead(4'd0, d);
    chk("R4 vector held", 32'(d), 32'd0);
    @(negedge clk);
    chk("R4 second rise", 32'(irqOut), 32'd1);
    ackRead(4'd3, d);
    chk("R4 vector relatched", 32'(d), 32'd3);

    // return from preemption: equal priority does not reassert
    srcPending = 4'b0001;
    eoiWrite(4'd3, 8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 no resume at equal prio", 32'(irqOut), 32'd0);
    end
    eoiWrite(4'd0, 8'h00);
    @(negedge clk);
    chk("R11 rise after lower restore", 32'(irqOut), 32'd1);
    ackRead(4'd0, d);
    chk("R11 vector", 32'(d), 32'd0);

    // write data ignored on EOI, upper bits ignored on priority write
    srcPending = '0;
    eoiWrite(4'd4, 8'hFF);
    rdReg(2'd2, d);
    chk("R8 write data ignored", 32'(d), 32'd4);
    wrReg(2'd2, 8'hF9);
    rdReg(2'd2, d);
    chk("R9 priority write/read", 32'(d), 32'd9);
    chk("R6 pushValid idle", 32'(pushValid), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule